// File: doc/BRIEF.md
# Flow-through no-turnaround synchronous SRAM

This block is a single-port synchronous static RAM with a flow-through read path and a late-write data path. Both reads and writes use the data bus in the cycle after the edge that registers their command, so reads and writes can be mixed on consecutive cycles with no idle cycle between them. Each word holds four lanes of nine bits: eight data bits and one parity bit. Software cannot reach the block. It is a storage macro that a controller drives directly.

A command is loaded on an active clock edge when `load_n` is low. Address, write enable, chip selects and burst order are all captured at that edge. While `load_n` stays high, a selected access continues as a four-beat burst. The two low address bits step in either linear or XOR order, and the upper address bits are held.

A `hold` input makes the block ignore a clock edge. Output enable and `sleep` gate the output drive without waiting for a clock edge. `sleep` also blocks all state changes, and the array keeps its contents. The data bus is split into `din`, `dout` and a drive-enable flag, `dout_en`, which the pad ring or bus fabric uses to control a tristate buffer.

Top module: `flowthru_sram`

## Requirements
- R1: While reset is low and after it is released, `dout_en` is 0 until a selected read command is loaded.
- R2: A read command is loaded on an edge where `hold`=0, `sleep`=0, `load_n`=0, `we_n`=1 and the chip is selected. In the cycle after that edge, `dout` shows the addressed word and `dout_en` is 1 while `oe_n` is 0.
- R3: A write's data is taken from `din` on the next active edge after the write command. Lane k is bits [9k+8:9k], with the parity bit at 9k+8. Lane k is written only where bit k of `lane_wr_n` was 0 when the beat was registered. Unwritten lanes keep their old value.
- R4: A write with `lane_wr_n`=4'b1111 changes nothing in the array, and `dout_en` stays 0 in its data cycle.
- R5: While `load_n`=1 after a selected load, each active edge advances a beat count modulo 4. The low two address bits are base+count when `wrap_xor` was 0 at load, and base XOR count when it was 1. The upper bits are unchanged.
- R6: The chip is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1 at a load. A load without selection sets `dout_en` to 0 in the next cycle, whatever `oe_n` is. Later edges with `load_n`=1 keep the chip deselected.
- R7: An edge with `hold`=1 is ignored. A read output keeps its value, and a pending write is not performed. The pending write takes `din` at the next edge with `hold`=0.
- R8: `oe_n`=1 forces `dout_en` to 0 at once, without waiting for a clock edge.
- R9: `sleep`=1 forces `dout_en` to 0 at once and blocks every write. The array keeps its contents. After `sleep` falls, the output stays undriven until a new selected read is loaded.
- R10: A read command may directly follow a write command. A read of the address written on the edge that registers the read returns the new data.
- R11: During a write burst, each beat uses the lane enables registered with that beat's own command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| hold | input | 1 | 1 = ignore this clock edge |
| load_n | input | 1 | 0 = load a new command, 1 = continue burst |
| addr | input | AW | Word address |
| we_n | input | 1 | 0 = write command |
| lane_wr_n | input | NB | Active-low per-lane write enables |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| wrap_xor | input | 1 | Burst order: 1 = XOR, 0 = linear |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous active-high sleep |
| din | input | NB*LW | Write data, sampled one active edge after the command |
| dout | output | NB*LW | Read data, 0 when not driven |
| dout_en | output | 1 | Output drive enable for the data bus |

## Verification
The bench builds the block with its defaults: 64 words (AW=6) and four nine-bit lanes. This depth is enough for bursts that start at every low-bit offset and wrap within an aligned group of four, next to words that the bursts must not touch. Each lane pattern is chosen so that a bit written to the wrong lane shows up in the read-back value, and each merged word is checked against a value worked out by hand. Deselect, hold, output-enable and sleep sequences are placed between accesses so that preserved data and held outputs can be observed directly at the ports.

// File: rtl/flowthru_sram.sv
module flowthru_sram #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             load_n,
  input  logic [AW-1:0]    addr,
  input  logic             we_n,
  input  logic [NB-1:0]    lane_wr_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             wrap_xor,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic [NB*LW-1:0] din,
  output logic [NB*LW-1:0] dout,
  output logic             dout_en
);
  localparam int DW    = NB * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          act, op_wr, wrap_q;
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q, lo;
  logic [NB-1:0] mask_q;
  logic [AW-1:0] eff;
  logic [DW-1:0] rd_word;
  logic          pick, step, wr_go;

  assign pick  = !sel_a_n && !sel_b_n && sel_c;
  assign step  = !hold && !sleep;
  assign lo    = wrap_q ? (base_q[1:0] ^ beat_q) : (base_q[1:0] + beat_q);
  assign eff   = {base_q[AW-1:2], lo};
  assign wr_go = step && act && op_wr;

  assign rd_word = mem[eff];
  assign dout_en = act && !op_wr && !oe_n && !sleep;
  assign dout    = dout_en ? rd_word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      op_wr  <= 1'b0;
      wrap_q <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '1;
    end else if (sleep) begin
      act <= 1'b0;
    end else if (!hold) begin
      mask_q <= lane_wr_n;
      if (!load_n) begin
        act    <= pick;
        op_wr  <= !we_n;
        wrap_q <= wrap_xor;
        base_q <= addr;
        beat_q <= '0;
      end else if (act) begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int k = 0; k < NB; k++) begin
        if (!mask_q[k]) mem[eff][k*LW +: LW] <= din[k*LW +: LW];
      end
    end
  end
endmodule

module flowthru_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          load_n,
  input logic          we_n,
  input logic          sel_a_n,
  input logic          sel_b_n,
  input logic          sel_c,
  input logic          oe_n,
  input logic          sleep,
  input logic          dout_en,
  input logic [DW-1:0] rd_word
);
  logic sel;
  assign sel = !sel_a_n && !sel_b_n && sel_c;

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !sleep && !load_n && sel && we_n) |=> (oe_n || sleep || dout_en));

  assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !sleep && !load_n && sel && !we_n) |=> !dout_en);

  assert_deselect_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !sleep && !load_n && !sel) |=> !dout_en);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !sleep) |=> $stable(rd_word));

  assert_oe_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  assert_sleep_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);
endmodule

bind flowthru_sram flowthru_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .load_n(load_n), .we_n(we_n),
  .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c), .oe_n(oe_n),
  .sleep(sleep), .dout_en(dout_en), .rd_word(rd_word)
);

// File: tb/flowthru_sram_tb.sv
module flowthru_sram_tb;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b0, load_n = 1'b1, we_n = 1'b1, sel_a_n = 1'b1, sel_b_n = 1'b1, sel_c = 1'b0;
  logic wrap_xor = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    lane_wr_n = 4'hF;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int runs = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flowthru_sram #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .load_n(load_n), .addr(addr), .we_n(we_n),
    .lane_wr_n(lane_wr_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .wrap_xor(wrap_xor), .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
  );

  typedef struct packed {
    logic          ld_n;
    logic          wen;
    logic [3:0]    bw;
    logic          sel;
    logic          hld;
    logic          xo;
    logic [5:0]    a;
    logic [35:0]   d;
    logic          en;
    logic [35:0]   q;
    logic [3:0]    rq;
  } vec_t;

  localparam vec_t TBL [31] = '{
    '{1'b0,1'b0,4'h0,1'b1,1'b0,1'b0,6'd4 ,36'h0        ,1'b0,36'h0        ,4'd3 }, // R3 write 4
    '{1'b0,1'b0,4'h0,1'b1,1'b0,1'b0,6'd5 ,36'h111111111,1'b0,36'h0        ,4'd3 }, // R3 write 5
    '{1'b0,1'b1,4'h0,1'b1,1'b0,1'b0,6'd4 ,36'hFFFFFFFFF,1'b1,36'h111111111,4'd10}, // R10 no gap
    '{1'b0,1'b1,4'h0,1'b1,1'b0,1'b0,6'd5 ,36'h0        ,1'b1,36'hFFFFFFFFF,4'd2 }, // R2
    '{1'b0,1'b0,4'hA,1'b1,1'b0,1'b0,6'd5 ,36'h0        ,1'b0,36'h0        ,4'd3 }, // R3 lanes 0,2
    '{1'b0,1'b1,4'h0,1'b1,1'b0,1'b0,6'd5 ,36'h333333333,1'b1,36'hFFB33FF33,4'd10}, // R10 R3 merge
    '{1'b0,1'b0,4'hF,1'b1,1'b0,1'b0,6'd4 ,36'h0        ,1'b0,36'h0        ,4'd4 }, // R4 abort
    '{1'b0,1'b1,4'h0,1'b1,1'b0,1'b0,6'd4 ,36'hABCDEF012,1'b1,36'h111111111,4'd4 }, // R4
    '{1'b0,1'b0,4'h0,1'b1,1'b0,1'b0,6'd10,36'h0        ,1'b0,36'h0        ,4'd5 }, // R5 burst wr
    '{1'b1,1'b1,4'h0,1'b1,1'b0,1'b0,6'd0 ,36'h00000000A,1'b0,36'h0        ,4'd5 },
    '{1'b1,1'b1,4'h0,1'b1,1'b0,1'b0,6'd0 ,36'h00000000B,1'b0,36'h0        ,4'd5 },
    '{1'b1,1'b1,4'h0,1'b1,1'b0,1'b0,6'd0 ,36'h00000000C,1'b0,36'h0        ,4'd5 },
    '{1'b0,1'b1,4'h0,1'b1,1'b0,1'b0,6'd9 ,36'h00000000D,1'b1,36'h00000000D,4'd5 }, // R5 linear rd
    '{1'b1,1'b1,4'h0,1'b1,1'b0,1'b0,6'd0 ,36'h0        ,1'b1,36'h00000000A,4'd5 },
    '{1'b1,1'b1,4'h0,1'b1,1'b0,1'b0,6'd0 ,36'h0        ,1'b1,36'h00000000B,4'd5 },
    '{1'b1,1'b1,4'h0,1'b1,1'b0,1'b0,6'd0 ,36'h0        ,1'b1,36'h00000000C,4'd5 },
    '{1'b0,1'b1,4'h0,1'b1,1'b0,1'b1,6'd9 ,36'h0        ,1'b1,36'h00000000D,4'd5 }, // R5 xor rd
    '{1'b1,1'b1,4'h0,1'b1,1'b0,1'b0,6'd0 ,36'h0        ,1'b1,36'h00000000C,4'd5 },
    '{1'b1,1'b1,4'h0,1'b1,1'b0,1'b0,6'd0 ,36'h0        ,1'b1,36'h00000000B,4'd5 },
    '{1'b1,1'b1,4'h0,1'b1,1'b0,1'b0,6'd0 ,36'h0        ,1'b1,36'h00000000A,4'd5 },
    '{1'b0,1'b1,4'h0,1'b0,1'b0,1'b0,6'd4 ,36'h0        ,1'b0,36'h0        ,4'd6 }, // R6 deselect
    '{1'b1,1'b1,4'h0,1'b0,1'b0,1'b0,6'd0 ,36'h0        ,1'b0,36'h0        ,4'd6 }, // R6 continue
    '{1'b0,1'b0,4'h0,1'b1,1'b0,1'b0,6'd4 ,36'h0        ,1'b0,36'h0        ,4'd11}, // R11 burst wr
    '{1'b1,1'b1,4'hE,1'b1,1'b0,1'b0,6'd0 ,36'h555555555,1'b0,36'h0        ,4'd11},
    '{1'b0,1'b1,4'h0,1'b1,1'b0,1'b0,6'd5 ,36'h0        ,1'b1,36'hFFB33FE00,4'd11}, // R11 lane0 only
    '{1'b0,1'b1,4'h0,1'b1,1'b0,1'b0,6'd4 ,36'h0        ,1'b1,36'h555555555,4'd11},
    '{1'b0,1'b0,4'h0,1'b1,1'b0,1'b0,6'd20,36'h0        ,1'b0,36'h0        ,4'd7 }, // R7 write 20
    '{1'b0,1'b1,4'h0,1'b1,1'b1,1'b0,6'd0 ,36'h0F0F0F0F0,1'b0,36'h0        ,4'd7 }, // R7 ignored
    '{1'b0,1'b1,4'h0,1'b1,1'b0,1'b0,6'd20,36'h123456789,1'b1,36'h123456789,4'd7 }, // R7 late data
    '{1'b0,1'b0,4'h0,1'b1,1'b1,1'b0,6'd4 ,36'h0        ,1'b1,36'h123456789,4'd7 }, // R7 hold output
    '{1'b0,1'b1,4'h0,1'b1,1'b0,1'b0,6'd4 ,36'h0        ,1'b1,36'h555555555,4'd7 }
  };

  task automatic check(input string tag, input logic ok, input logic en_a, input logic [35:0] q_a,
                       input logic en_e, input logic [35:0] q_e);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: en=%b dout=%h expected en=%b dout=%h", tag, en_a, q_a, en_e, q_e);
    end
  endtask

  task automatic drive(input vec_t v);
    load_n = v.ld_n; we_n = v.wen; lane_wr_n = v.bw; hold = v.hld; wrap_xor = v.xo;
    addr = v.a; din = v.d;
    sel_a_n = !v.sel; sel_b_n = !v.sel; sel_c = v.sel;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: en=%b dout=%h expected en=0 dout=0", dout_en, dout);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 check("R1 in reset", dout_en === 1'b0, dout_en, dout, 1'b0, 36'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1 after reset", dout_en === 1'b0, dout_en, dout, 1'b0, 36'h0);

    for (int i = 0; i < 31; i++) begin
      @(negedge clk) drive(TBL[i]);
      @(posedge clk);
      #1;
      if (TBL[i].en)
        check($sformatf("R%0d row %0d", TBL[i].rq, i),
              dout_en === 1'b1 && dout === TBL[i].q, dout_en, dout, 1'b1, TBL[i].q);
      else
        check($sformatf("R%0d row %0d", TBL[i].rq, i),
              dout_en === 1'b0, dout_en, dout, 1'b0, 36'h0);
    end

    oe_n = 1'b1;
    #1 check("R8 oe high", dout_en === 1'b0, dout_en, dout, 1'b0, 36'h0);
    oe_n = 1'b0;
    #1 check("R8 oe low", dout_en === 1'b1 && dout === 36'h555555555, dout_en, dout, 1'b1, 36'h555555555);

    @(negedge clk);
    sleep = 1'b1;
    #1 check("R9 sleep float", dout_en === 1'b0, dout_en, dout, 1'b0, 36'h0);
    load_n = 1'b0; we_n = 1'b0; lane_wr_n = 4'h0; addr = 6'd4; din = 36'h0;
    sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b1; hold = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R9 asleep", dout_en === 1'b0, dout_en, dout, 1'b0, 36'h0);
    @(negedge clk);
    sleep = 1'b0; load_n = 1'b1;
    #1 check("R9 woken idle", dout_en === 1'b0, dout_en, dout, 1'b0, 36'h0);
    @(posedge clk);
    #1 check("R9 idle after edge", dout_en === 1'b0, dout_en, dout, 1'b0, 36'h0);
    @(negedge clk);
    load_n = 1'b0; we_n = 1'b1; addr = 6'd4;
    @(posedge clk);
    #1 check("R9 retained", dout_en === 1'b1 && dout === 36'h555555555, dout_en, dout, 1'b1, 36'h555555555);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule